// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Port Window

This block lets a host reach PCI configuration space and PCI I/O port space through a small register window. The host first loads a 32-bit target token into an address register. It then reads or writes one of two data windows. The configuration window turns each access into one configuration cycle request. The I/O window turns each access into one I/O cycle request. The low two bits of the window offset pick the byte lanes for byte and halfword accesses.

Each data-window access becomes exactly one request on a simple downstream request/acknowledge port. That request carries the command, the target address, the byte enables and the write data. The host access is stalled until the acknowledge comes back, and a read returns the downstream data in its natural lanes. The token stays loaded after use, so a driver can load it once and then make several window accesses. Accesses to the address register and to offsets with no function finish without waiting.

Top module: `pciw_bridge`

## Requirements
- R1: After reset the token register reads as zero, no downstream request is pending (`dn_valid_o` low) and `req_ready_o` is low while no host access is presented.
- R2: An access to offset 0x064 (any access size, offsets 0x064 to 0x067) completes in the cycle it is presented, with `req_ready_o` high in that same cycle. A write loads all 32 bits of `req_wdata_i` into the token register. A read returns the stored token. No downstream request is made.
- R3: An access to offsets 0x068 to 0x06B issues one configuration request. `dn_cmd_o` is 0 for a read and 1 for a write. `dn_addr_o` is {8'h00, token[23:2], 2'b00}: bus in bits 23:16, device-function in bits 15:8 and register in bits 7:2, with the top byte and the low two bits zero.
- R4: An access to offsets 0x06C to 0x06F issues one I/O request. `dn_cmd_o` is 2 for a read and 3 for a write. `dn_addr_o` is {16'h0000, token[15:0]}.
- R5: `req_size_i` encodes 0 as byte, 1 as halfword and 2 or 3 as word. The byte enables are active high with bit n for lane n: 4'b0001 shifted left by offset[1:0] for a byte, 4'b0011 shifted left by (offset & 2) for a halfword, and 4'b1111 for a word.
- R6: `dn_wdata_o` carries `req_wdata_i` unchanged. A window read returns `dn_rdata_i` unshifted on `req_rdata_o`. A window write returns zero.
- R7: A window access holds `req_ready_o` low until the acknowledge. `req_ready_o` goes high for exactly one cycle, the cycle after `dn_ack_i` is sampled high. The request first appears the cycle after the access is presented, so a request acknowledged after d wait cycles gives ready 2+d cycles after presentation.
- R8: `dn_valid_o` and all request fields stay stable until `dn_ack_i`. Exactly one request is made for each window access, and `req_ready_o` is never high while a request is pending.
- R9: The token is held across any number of window accesses and changes only on a write to the address register.
- R10: Accesses to any other offset complete in the cycle they are presented, make no downstream request, and return zero on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host access presented; held until accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the access within the register window |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata_i | input | 32 | Host write data, placed in its natural lanes |
| req_ready_o | output | 1 | Access accepted on this clock edge |
| req_rdata_o | output | 32 | Read data, valid while req_ready_o is high |
| dn_valid_o | output | 1 | Downstream request pending |
| dn_cmd_o | output | 2 | 0 cfg read, 1 cfg write, 2 I/O read, 3 I/O write |
| dn_addr_o | output | 32 | Configuration or I/O target address |
| dn_be_o | output | 4 | Active-high byte enables |
| dn_wdata_o | output | 32 | Write data |
| dn_ack_i | input | 1 | Downstream completion |
| dn_rdata_i | input | 32 | Downstream read data, valid with dn_ack_i |

## Verification
Two events can land in the same cycle: the downstream acknowledge and the first cycle of its request. This is provoked by answering with zero wait states, so that the acknowledge is already high on the first clock edge on which `dn_valid_o` is seen. It is judged by checking that the scoreboard pops exactly one request and that ready arrives at exactly presentation plus two cycles. A second overlap is a token reload presented on the edge right after a window completion. It must take effect once and steer the very next configuration request to the new address.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WIDE = 2'd3} size_e;
  typedef enum logic [1:0] {CMD_CFG_RD = 2'd0, CMD_CFG_WR = 2'd1, CMD_IO_RD = 2'd2, CMD_IO_WR = 2'd3} cmd_e;
  typedef enum logic [1:0] {WIN_NONE, WIN_TOKEN, WIN_CFG, WIN_IO} win_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} xst_e;

  typedef struct packed {
    logic [1:0]  cmd;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
  } dn_req_t;
endpackage

// File: rtl/pciw_decode.sv
module pciw_decode #(
  parameter int ADDR_W   = 12,
  parameter int LANES    = 4,
  parameter int OFS_TOK  = 'h064,
  parameter int OFS_CFG  = 'h068,
  parameter int OFS_IO   = 'h06C
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  output pciw_pkg::win_e     win_o,
  output logic [LANES-1:0]   be_o
);
  import pciw_pkg::*;

  localparam int LW = $clog2(LANES);
  localparam logic [ADDR_W-LW-1:0] IDX_TOK = ADDR_W'(OFS_TOK) >> LW;
  localparam logic [ADDR_W-LW-1:0] IDX_CFG = ADDR_W'(OFS_CFG) >> LW;
  localparam logic [ADDR_W-LW-1:0] IDX_IO  = ADDR_W'(OFS_IO)  >> LW;

  logic [ADDR_W-LW-1:0] idx;
  logic [LW-1:0]        lane;

  assign idx  = addr_i[ADDR_W-1:LW];
  assign lane = addr_i[LW-1:0];

  always_comb begin
    if (idx == IDX_CFG)      win_o = WIN_CFG;
    else if (idx == IDX_IO)  win_o = WIN_IO;
    else if (idx == IDX_TOK) win_o = WIN_TOKEN;
    else                     win_o = WIN_NONE;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    localparam logic [LW-1:0] LN = LW'(l);
    always_comb begin
      unique case (size_e'(size_i))
        SZ_BYTE: be_o[l] = (lane == LN);
        SZ_HALF: be_o[l] = (lane[LW-1:1] == LN[LW-1:1]);
        default: be_o[l] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pciw_token_reg.sv
module pciw_token_reg #(
  parameter int DATA_W   = 32,
  parameter int IOADDR_W = 16,
  parameter int CFGTOK_W = 24,
  parameter int ALIGN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] tok_o,
  output logic [DATA_W-1:0] cfg_addr_o,
  output logic [DATA_W-1:0] io_addr_o
);
  logic [DATA_W-1:0] tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tok_q <= '0;
    else if (wr_en_i) tok_q <= wdata_i;
  end

  assign tok_o      = tok_q;
  // register number is dword aligned; upper byte is not part of the token
  assign cfg_addr_o = {{(DATA_W-CFGTOK_W){1'b0}}, tok_q[CFGTOK_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign io_addr_o  = {{(DATA_W-IOADDR_W){1'b0}}, tok_q[IOADDR_W-1:0]};

  // R9
  tok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(tok_q));
endmodule

// File: rtl/pciw_xact.sv
module pciw_xact (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  pciw_pkg::dn_req_t  req_i,
  input  logic               dn_ack_i,
  input  logic [31:0]        dn_rdata_i,
  output logic               dn_valid_o,
  output pciw_pkg::dn_req_t  dn_req_o,
  output logic               idle_o,
  output logic               done_o,
  output logic [31:0]        rsp_o
);
  import pciw_pkg::*;

  xst_e        st_q;
  dn_req_t     req_q;
  logic [31:0] rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
      rsp_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          req_q <= req_i;
          st_q  <= ST_ISSUE;
        end
        ST_ISSUE: if (dn_ack_i) begin
          rsp_q <= req_q.cmd[0] ? '0 : dn_rdata_i;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_valid_o = (st_q == ST_ISSUE);
  assign dn_req_o   = req_q;
  assign idle_o     = (st_q == ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign rsp_o      = rsp_q;

  // R8
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ack_i |=> dn_valid_o && $stable(dn_req_o));
  // R7
  ack_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && dn_ack_i |=> done_o && !dn_valid_o);
  // R7
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/pciw_bridge.sv
module pciw_bridge #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int OFS_TOK = 'h064,
  parameter int OFS_CFG = 'h068,
  parameter int OFS_IO  = 'h06C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              dn_valid_o,
  output logic [1:0]        dn_cmd_o,
  output logic [DATA_W-1:0] dn_addr_o,
  output logic [3:0]        dn_be_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_ack_i,
  input  logic [DATA_W-1:0] dn_rdata_i
);
  import pciw_pkg::*;

  localparam int LANES = DATA_W / 8;

  win_e              win;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] tok, cfg_addr, io_addr;
  logic              idle, done, start, imm_ready, tok_wr;
  logic [DATA_W-1:0] rsp;
  dn_req_t           req_new, req_out;

  pciw_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES),
    .OFS_TOK(OFS_TOK), .OFS_CFG(OFS_CFG), .OFS_IO(OFS_IO)
  ) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i), .win_o(win), .be_o(be)
  );

  pciw_token_reg #(.DATA_W(DATA_W)) u_tok (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(tok_wr), .wdata_i(req_wdata_i),
    .tok_o(tok), .cfg_addr_o(cfg_addr), .io_addr_o(io_addr)
  );

  assign imm_ready = idle && req_valid_i && (win == WIN_TOKEN || win == WIN_NONE);
  assign start     = idle && req_valid_i && (win == WIN_CFG || win == WIN_IO);
  assign tok_wr    = imm_ready && req_write_i && (win == WIN_TOKEN);

  always_comb begin
    req_new.cmd   = {win == WIN_IO, req_write_i};
    req_new.addr  = (win == WIN_IO) ? io_addr : cfg_addr;
    req_new.be    = be;
    req_new.wdata = req_wdata_i;
  end

  pciw_xact u_xact (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .req_i(req_new),
    .dn_ack_i(dn_ack_i), .dn_rdata_i(dn_rdata_i), .dn_valid_o(dn_valid_o),
    .dn_req_o(req_out), .idle_o(idle), .done_o(done), .rsp_o(rsp)
  );

  assign dn_cmd_o    = req_out.cmd;
  assign dn_addr_o   = req_out.addr;
  assign dn_be_o     = req_out.be;
  assign dn_wdata_o  = req_out.wdata;
  assign req_ready_o = done || imm_ready;
  assign req_rdata_o = done ? rsp : (imm_ready && win == WIN_TOKEN) ? tok : '0;

  // R8
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && dn_valid_o));
  // R5
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> ($countones(dn_be_o) == 1 || $countones(dn_be_o) == 2 || dn_be_o == 4'hF));
  // R3
  cfg_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_cmd_o[1] |-> dn_addr_o[31:24] == 8'h00 && dn_addr_o[1:0] == 2'b00);
  // R4
  io_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && dn_cmd_o[1] |-> dn_addr_o[31:16] == 16'h0000);
  // R10
  undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_write_i && !dn_valid_o &&
    (req_addr_i[ADDR_W-1:2] < 10'h019 || req_addr_i[ADDR_W-1:2] > 10'h01B)
    |-> req_rdata_o == '0);
endmodule

// File: tb/pciw_bridge_test.sv
`timescale 1ns/1ps
module pciw_bridge_test;
  localparam logic [31:0] MAGIC = 32'h5A00_00C3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o;
  logic [31:0] req_rdata_o;
  logic        dn_valid_o;
  logic [1:0]  dn_cmd_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic [3:0]  dn_be_o;
  logic        dn_ack_i = 1'b0;
  logic [31:0] dn_rdata_i = '0;

  int n_chk = 0, n_fail = 0;
  int ack_dly = 0, wcnt = 0;
  logic [31:0] tok_model = '0;
  logic [69:0] exp_q[$];

  always #4 clk = ~clk;

  pciw_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .req_rdata_o(req_rdata_o), .dn_valid_o(dn_valid_o),
    .dn_cmd_o(dn_cmd_o), .dn_addr_o(dn_addr_o), .dn_be_o(dn_be_o), .dn_wdata_o(dn_wdata_o),
    .dn_ack_i(dn_ack_i), .dn_rdata_i(dn_rdata_i)
  );

  task automatic check(input bit ok, input string req, input logic [69:0] act, input logic [69:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // downstream model + scoreboard monitor
  always @(negedge clk) begin
    if (dn_valid_o) begin
      if (wcnt >= ack_dly) begin
        logic [69:0] got, exp;
        dn_ack_i   = 1'b1;
        dn_rdata_i = dn_addr_o ^ MAGIC;
        wcnt       = 0;
        got = {dn_cmd_o, dn_addr_o, dn_be_o, dn_wdata_o};
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected request", got, '0);
        else begin
          exp = exp_q.pop_front();
          check(got == exp, "R3/R4/R5/R6 request", got, exp);
        end
      end else begin
        dn_ack_i = 1'b0;
        wcnt++;
      end
    end else begin
      dn_ack_i = 1'b0;
      wcnt     = 0;
    end
  end

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [11:0] a);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return 4'b0011 << {a[1], 1'b0};
      default: return 4'hF;
    endcase
  endfunction

  task automatic host(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input bit win, input logic [31:0] eaddr,
                      input int d, input logic [31:0] erd, input bit chk_rd, input string tag);
    int n = 0;
    logic [31:0] got;
    if (win) begin
      exp_q.push_back({{a[2], wr}, eaddr, exp_be(sz, a), wd});
      ack_dly = d;
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_size_i = sz; req_wdata_i = wd;
    #1;
    while (!req_ready_o && n < 60) begin
      @(negedge clk); #1; n++;
    end
    got = req_rdata_o;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    check(n == (win ? 2 + d : 0), {tag, " R7/R10 ready latency"}, 70'(n), 70'(win ? 2 + d : 0));
    if (chk_rd) check(got == erd, {tag, " read data"}, 70'(got), 70'(erd));
    if (!win && wr && a[11:2] == 10'h019) tok_model = wd;
  endtask

  task automatic cfg(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input int d, input string tag);
    logic [31:0] ea = {8'h00, tok_model[23:2], 2'b00};
    host(wr, a, sz, wd, 1'b1, ea, d, wr ? 32'h0 : ea ^ MAGIC, 1'b1, tag);
  endtask

  task automatic io(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, input int d, input string tag);
    logic [31:0] ea = {16'h0000, tok_model[15:0]};
    host(wr, a, sz, wd, 1'b1, ea, d, wr ? 32'h0 : ea ^ MAGIC, 1'b1, tag);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dn_valid_o == 1'b0, "R1 dn_valid after reset", 70'(dn_valid_o), 70'(0));
    check(req_ready_o == 1'b0, "R1 ready idle", 70'(req_ready_o), 70'(0));
    rst_ni = 1'b1;
    host(1'b0, 12'h064, 2'd2, 32'h0, 1'b0, '0, 0, 32'h0, 1'b1, "R1 token reset");
    // R2 token load and readback
    host(1'b1, 12'h064, 2'd2, 32'hAB12_3457, 1'b0, '0, 0, 32'h0, 1'b0, "R2 load");
    host(1'b0, 12'h066, 2'd0, 32'h0, 1'b0, '0, 0, 32'hAB12_3457, 1'b1, "R2 readback");
    // R3 config window, several sizes and waits; R9 reuse of one token
    cfg(1'b0, 12'h068, 2'd2, 32'h0, 0, "R3 cfg word read zero-wait");
    cfg(1'b1, 12'h069, 2'd0, 32'h0000_5500, 2, "R3 R5 R6 cfg byte write");
    cfg(1'b0, 12'h06A, 2'd1, 32'h0, 1, "R3 R5 R9 cfg half read");
    cfg(1'b1, 12'h06B, 2'd0, 32'hCC00_0000, 0, "R5 cfg top byte");
    // R4 I/O window
    io(1'b1, 12'h06F, 2'd0, 32'h7700_0000, 1, "R4 R5 io byte write");
    io(1'b0, 12'h06C, 2'd1, 32'h0, 0, "R4 R5 io half read");
    io(1'b1, 12'h06C, 2'd2, 32'hDEAD_BEEF, 3, "R4 R6 io word write");
    io(1'b0, 12'h06D, 2'd3, 32'h0, 2, "R5 io wide size as word");
    io(1'b0, 12'h06E, 2'd1, 32'h0, 0, "R5 io upper half");
    // R10 undefined offsets
    host(1'b0, 12'h000, 2'd2, 32'h0, 1'b0, '0, 0, 32'h0, 1'b1, "R10 read 0x000");
    host(1'b1, 12'h070, 2'd2, 32'hFFFF_FFFF, 1'b0, '0, 0, 32'h0, 1'b0, "R10 write 0x070");
    host(1'b0, 12'h060, 2'd2, 32'h0, 1'b0, '0, 0, 32'h0, 1'b1, "R10 read 0x060");
    host(1'b0, 12'hFFC, 2'd0, 32'h0, 1'b0, '0, 0, 32'h0, 1'b1, "R10 read 0xFFC");
    host(1'b0, 12'h064, 2'd2, 32'h0, 1'b0, '0, 0, 32'hAB12_3457, 1'b1, "R9 R10 token untouched");
    // token reload right after a completion, then use it
    cfg(1'b0, 12'h068, 2'd2, 32'h0, 0, "R8 completion before reload");
    host(1'b1, 12'h064, 2'd2, 32'h0003_F8FF, 1'b0, '0, 0, 32'h0, 1'b0, "R2 reload");
    cfg(1'b0, 12'h068, 2'd2, 32'h0, 0, "R3 R9 new token cfg");
    io(1'b0, 12'h06C, 2'd2, 32'h0, 1, "R4 new token io");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all requests issued", 70'(exp_q.size()), 70'(0));
    check(dn_valid_o == 1'b0, "R8 no stray request", 70'(dn_valid_o), 70'(0));
    finish_run();
  end
endmodule